// File: doc/BRIEF.md
# MAC Control Frame Receive Classifier

This block sits on a byte-serial receive stream and inspects each Ethernet frame as it passes. It decides whether the frame is a MAC control frame. The frame must meet all of the following: its destination matches a configured multicast or unicast address, its source matches a configured address, its EtherType equals a configured value, and its opcode belongs to an accepted class. Every address comparison and each of the two opcode classes has its own enable. A comparison whose enable is low counts as matched.

Every frame is passed downstream unchanged, one cycle later. The exception is a matched control frame when forwarding is off: the classifier then raises the bad-frame user bit on its final beat, so a later stage can drop it. For every matched frame that arrived without an error, the block pulses a control-output strobe. The strobe carries the opcode, a class code and the parameter words that were pulled out of the payload. There are two opcode classes. A link pause frame carries one quanta word. A priority pause frame carries a class-enable word followed by one quanta word per class. A global enable turns the whole classifier off.

Top module: `mcf_rx_classifier`

## Requirements
- R1: Each input beat (valid, data, last) appears unchanged on the output exactly one clock later.
- R2: Frame bytes are numbered from 0. The destination occupies bytes 0-5, the source bytes 6-11, the EtherType bytes 12-13 and the opcode bytes 14-15, all most significant byte first. The EtherType is always compared. A frame shorter than 16 bytes is never a control frame.
- R3: The destination passes when the multicast check is enabled and matches, or when the unicast check is enabled and matches. When both destination checks are disabled, any destination passes.
- R4: With the source check enabled, a frame whose source differs from the configured source is not a control frame. With the check disabled, the source is ignored.
- R5: With either opcode check enabled, the opcode must equal an enabled class value. With both opcode checks disabled, any opcode is accepted. ctl_kind reports 1 when the opcode equals the link value, 2 when it equals the priority value, and 0 otherwise.
- R6: With forwarding off, a control frame leaves with out_user set on its final beat. With forwarding on, the final-beat out_user equals the incoming in_user.
- R7: For a frame that is not a control frame, out_user on every beat equals in_user of the same beat, delayed by one cycle.
- R8: ctl_valid is a one-cycle pulse. It is high in the same cycle as the output final beat of a control frame, and only when in_user was low on the input final beat.
- R9: While ctl_valid is high, ctl_opcode holds bytes 14-15, and ctl_word0 holds bytes 16-17 (the link quanta, or the priority class-enable vector). ctl_prio_quanta[16*i+:16] holds bytes 18+2i and 19+2i. A byte beyond the frame end reads as zero.
- R10: With cfg_enable low, no frame is marked and ctl_valid stays low.
- R11: During and just after reset, out_valid and ctl_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Classifier on |
| cfg_forward | input | 1 | Pass control frames without the bad mark |
| cfg_mcast_addr | input | 48 | Multicast destination to compare |
| cfg_mcast_chk | input | 1 | Multicast destination check enable |
| cfg_ucast_addr | input | 48 | Unicast destination to compare |
| cfg_ucast_chk | input | 1 | Unicast destination check enable |
| cfg_src_addr | input | 48 | Source address to compare |
| cfg_src_chk | input | 1 | Source check enable |
| cfg_ethtype | input | 16 | EtherType of control frames |
| cfg_link_op | input | 16 | Link pause opcode value |
| cfg_link_chk | input | 1 | Link opcode class enable |
| cfg_prio_op | input | 16 | Priority pause opcode value |
| cfg_prio_chk | input | 1 | Priority opcode class enable |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input final byte of frame |
| in_user | input | 1 | Input bad-frame bit |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output final byte |
| out_user | output | 1 | Output bad-frame bit |
| ctl_valid | output | 1 | Extracted control parameters strobe |
| ctl_kind | output | 2 | Opcode class code |
| ctl_opcode | output | 16 | Extracted opcode |
| ctl_word0 | output | 16 | Link quanta or priority class-enable vector |
| ctl_prio_quanta | output | 128 | Per-class quanta, class i at bits 16*i+15:16*i |

## Verification
Three cases are hard to reach from the ports. The first is a frame that ends inside the header or parameter area: the match decision, and which bytes read as zero, depend on exactly where the last beat lands. The second is a matched frame that carries an upstream error on its final beat, which must still be marked but must not strobe. The third is the detailed interaction between the check enables. The stimulus builds each frame byte by byte from field values and a length taken from a vector table, so truncation at 15, 17 and 25 bytes comes out of the table. A directed errored frame follows the table.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
  localparam int unsigned OFF_DST   = 0;
  localparam int unsigned OFF_SRC   = 6;
  localparam int unsigned OFF_TYPE  = 12;
  localparam int unsigned OFF_OP    = 14;
  localparam int unsigned HDR_LEN   = 16;
  localparam int unsigned OFF_PARAM = 16;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_LINK  = 2'd1,
    KIND_PRIO  = 2'd2
  } ctl_kind_e;

  typedef struct packed {
    logic mc;
    logic uc;
    logic sa;
    logic et;
    logic lop;
    logic pop;
  } hdr_hits_t;

  // byte k (0 = most significant) of a 48-bit address
  function automatic logic [7:0] be_byte48(input logic [47:0] v, input int unsigned k);
    logic [47:0] t;
    t = v >> (8 * (5 - k));
    return t[7:0];
  endfunction

  // byte k (0 = most significant) of a 16-bit field
  function automatic logic [7:0] be_byte16(input logic [15:0] v, input int unsigned k);
    return (k == 0) ? v[15:8] : v[7:0];
  endfunction

  function automatic logic dst_pass(input logic mchk, input logic mhit,
                                    input logic uchk, input logic uhit);
    return (!mchk && !uchk) || (mchk && mhit) || (uchk && uhit);
  endfunction

  function automatic logic op_pass(input logic lchk, input logic lhit,
                                   input logic pchk, input logic phit);
    return (!lchk && !pchk) || (lchk && lhit) || (pchk && phit);
  endfunction

  function automatic ctl_kind_e op_kind(input logic lhit, input logic phit);
    if (lhit) return KIND_LINK;
    if (phit) return KIND_PRIO;
    return KIND_OTHER;
  endfunction
endpackage

// File: rtl/mcf_hdr_match.sv
module mcf_hdr_match
  import mcf_pkg::*;
#(
  parameter int unsigned IDX_MAX = 34,
  localparam int unsigned IDX_W  = $clog2(IDX_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_valid,
  input  logic [7:0]       beat_data,
  input  logic             beat_last,
  input  logic [47:0]      mcast_addr,
  input  logic [47:0]      ucast_addr,
  input  logic [47:0]      src_addr,
  input  logic [15:0]      ethtype,
  input  logic [15:0]      link_op,
  input  logic [15:0]      prio_op,
  output logic [IDX_W-1:0] byte_idx,
  output logic             frame_start,
  output logic             hdr_full,
  output hdr_hits_t        hits
);
  logic [IDX_W-1:0] idx_q;
  hdr_hits_t        hits_q;
  hdr_hits_t        hits_n;
  int unsigned      cur_k;

  assign cur_k       = 32'(idx_q);
  assign byte_idx    = idx_q;
  assign frame_start = beat_valid && (idx_q == '0);
  assign hdr_full    = cur_k >= (HDR_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (beat_valid) begin
      if (beat_last)                     idx_q <= '0;
      else if (cur_k != IDX_MAX)         idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    hits_n = frame_start ? '1 : hits_q;
    if (beat_valid) begin
      if (cur_k < OFF_SRC) begin
        hits_n.mc &= (beat_data == be_byte48(mcast_addr, cur_k - OFF_DST));
        hits_n.uc &= (beat_data == be_byte48(ucast_addr, cur_k - OFF_DST));
      end else if (cur_k < OFF_TYPE) begin
        hits_n.sa &= (beat_data == be_byte48(src_addr, cur_k - OFF_SRC));
      end else if (cur_k < OFF_OP) begin
        hits_n.et &= (beat_data == be_byte16(ethtype, cur_k - OFF_TYPE));
      end else if (cur_k < HDR_LEN) begin
        hits_n.lop &= (beat_data == be_byte16(link_op, cur_k - OFF_OP));
        hits_n.pop &= (beat_data == be_byte16(prio_op, cur_k - OFF_OP));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hits_q <= '0;
    else if (beat_valid) hits_q <= hits_n;
  end

  assign hits = hits_n;
endmodule

// File: rtl/mcf_param_capture.sv
module mcf_param_capture
  import mcf_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = 8,
  parameter int unsigned IDX_W       = 6,
  localparam int unsigned CAP_FIRST  = OFF_OP,
  localparam int unsigned CAP_BYTES  = 4 + 2 * NUM_CLASSES
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat_valid,
  input  logic [7:0]                beat_data,
  input  logic                      frame_start,
  input  logic [IDX_W-1:0]          byte_idx,
  output logic [15:0]               opcode,
  output logic [15:0]               word0,
  output logic [16*NUM_CLASSES-1:0] class_quanta
);
  logic [8*CAP_BYTES-1:0] cap_flat;

  for (genvar g = 0; g < CAP_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 b_q <= '0;
      else if (frame_start)       b_q <= '0;
      else if (beat_valid && (32'(byte_idx) == CAP_FIRST + g))
                                  b_q <= beat_data;
    end
    assign cap_flat[8*g +: 8] = b_q;
  end

  assign opcode = {cap_flat[0 +: 8], cap_flat[8 +: 8]};
  assign word0  = {cap_flat[16 +: 8], cap_flat[24 +: 8]};

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    assign class_quanta[16*c +: 16] = {cap_flat[8*(4+2*c) +: 8], cap_flat[8*(5+2*c) +: 8]};
  end
endmodule

// File: rtl/mcf_stream_mark.sv
module mcf_stream_mark #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_user,
  input  logic              mark_bad,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_user
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_user  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_data;
      out_last  <= in_last;
      out_user  <= in_user | (in_valid & in_last & mark_bad);
    end
  end
endmodule

// File: rtl/mcf_rx_classifier.sv
module mcf_rx_classifier
  import mcf_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_enable,
  input  logic                      cfg_forward,
  input  logic [47:0]               cfg_mcast_addr,
  input  logic                      cfg_mcast_chk,
  input  logic [47:0]               cfg_ucast_addr,
  input  logic                      cfg_ucast_chk,
  input  logic [47:0]               cfg_src_addr,
  input  logic                      cfg_src_chk,
  input  logic [15:0]               cfg_ethtype,
  input  logic [15:0]               cfg_link_op,
  input  logic                      cfg_link_chk,
  input  logic [15:0]               cfg_prio_op,
  input  logic                      cfg_prio_chk,
  input  logic                      in_valid,
  input  logic [7:0]                in_data,
  input  logic                      in_last,
  input  logic                      in_user,
  output logic                      out_valid,
  output logic [7:0]                out_data,
  output logic                      out_last,
  output logic                      out_user,
  output logic                      ctl_valid,
  output logic [1:0]                ctl_kind,
  output logic [15:0]               ctl_opcode,
  output logic [15:0]               ctl_word0,
  output logic [16*NUM_CLASSES-1:0] ctl_prio_quanta
);
  localparam int unsigned IDX_MAX = OFF_PARAM + 2 + 2 * NUM_CLASSES;
  localparam int unsigned IDX_W   = $clog2(IDX_MAX + 1);

  logic [IDX_W-1:0] byte_idx;
  logic             frame_start;
  logic             hdr_full;
  hdr_hits_t        hits;
  logic             frame_end;
  logic             ctl_hit;
  logic             mark_bad;
  ctl_kind_e        kind_q;

  mcf_hdr_match #(.IDX_MAX(IDX_MAX)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (in_valid),
    .beat_data  (in_data),
    .beat_last  (in_last),
    .mcast_addr (cfg_mcast_addr),
    .ucast_addr (cfg_ucast_addr),
    .src_addr   (cfg_src_addr),
    .ethtype    (cfg_ethtype),
    .link_op    (cfg_link_op),
    .prio_op    (cfg_prio_op),
    .byte_idx   (byte_idx),
    .frame_start(frame_start),
    .hdr_full   (hdr_full),
    .hits       (hits)
  );

  mcf_param_capture #(.NUM_CLASSES(NUM_CLASSES), .IDX_W(IDX_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_valid  (in_valid),
    .beat_data   (in_data),
    .frame_start (frame_start),
    .byte_idx    (byte_idx),
    .opcode      (ctl_opcode),
    .word0       (ctl_word0),
    .class_quanta(ctl_prio_quanta)
  );

  assign frame_end = in_valid && in_last;
  assign ctl_hit   = cfg_enable && frame_end && hdr_full
                  && dst_pass(cfg_mcast_chk, hits.mc, cfg_ucast_chk, hits.uc)
                  && (!cfg_src_chk || hits.sa)
                  && hits.et
                  && op_pass(cfg_link_chk, hits.lop, cfg_prio_chk, hits.pop);
  assign mark_bad  = ctl_hit && !cfg_forward;

  mcf_stream_mark #(.DATA_W(8)) u_mark (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_user  (in_user),
    .mark_bad (mark_bad),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last),
    .out_user (out_user)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_valid <= 1'b0;
      kind_q    <= KIND_OTHER;
    end else begin
      ctl_valid <= ctl_hit && !in_user;
      if (ctl_hit) kind_q <= op_kind(hits.lop, hits.pop);
    end
  end

  assign ctl_kind = kind_q;
endmodule

// File: rtl/mcf_rx_classifier_chk.sv
module mcf_rx_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_enable,
  input logic       cfg_forward,
  input logic       in_valid,
  input logic       in_last,
  input logic       in_user,
  input logic       out_valid,
  input logic       out_last,
  input logic       out_user,
  input logic       ctl_valid,
  input logic [1:0] ctl_kind,
  input logic       ctl_hit
);
  AST_PASS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R1
  AST_PASS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_last == $past(in_last)); // R1
  AST_STROBE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> out_valid && out_last); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !ctl_valid); // R8
  AST_STROBE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> !$past(in_user)); // R8
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> ctl_kind != 2'd3); // R5
  AST_USER_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> out_user == $past(in_user)); // R7
  AST_MARK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && out_user) |-> ($past(in_user) || $past(ctl_hit && !cfg_forward))); // R6
  AST_FWD_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_forward)) |-> out_user == $past(in_user)); // R6
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> $past(cfg_enable)); // R10
endmodule

bind mcf_rx_classifier mcf_rx_classifier_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .cfg_forward(cfg_forward),
  .in_valid   (in_valid),
  .in_last    (in_last),
  .in_user    (in_user),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .out_user   (out_user),
  .ctl_valid  (ctl_valid),
  .ctl_kind   (ctl_kind),
  .ctl_hit    (ctl_hit)
);

// File: tb/mcf_rx_classifier_tb_top.sv
module mcf_rx_classifier_tb_top;
  localparam int NCL = 8;
  localparam logic [47:0] MC = 48'h0180C2000001;
  localparam logic [47:0] UC = 48'hDAD1D2D3D4D5;
  localparam logic [47:0] SA = 48'h5A5152535455;
  // cfg bits: [5] enable [4] forward [3] mcast chk [2] ucast chk [1] src chk [0] opcode chks
  localparam logic [5:0] C_STD   = 6'b101001;
  localparam logic [5:0] C_FWD   = 6'b111001;
  localparam logic [5:0] C_UC    = 6'b101101;
  localparam logic [5:0] C_OFF   = 6'b001001;
  localparam logic [5:0] C_SRC   = 6'b101011;
  localparam logic [5:0] C_NODST = 6'b100001;
  localparam logic [5:0] C_NOOP  = 6'b101000;

  typedef struct packed {
    logic [47:0] dst;
    logic [47:0] src;
    logic [15:0] etype;
    logic [15:0] op;
    logic [7:0]  len;
    logic [5:0]  cfg;
    logic        exp_mark;
    logic        exp_valid;
    logic [1:0]  exp_kind;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{MC, SA, 16'h8808, 16'h0001, 8'd64, C_STD,   1'b1, 1'b1, 2'd1}, // R2 R6 link frame marked
    '{MC, SA, 16'h8808, 16'h0001, 8'd64, C_FWD,   1'b0, 1'b1, 2'd1}, // R6 forwarded
    '{MC, SA, 16'h8808, 16'h0101, 8'd64, C_STD,   1'b1, 1'b1, 2'd2}, // R5 R9 priority frame
    '{MC, SA, 16'h0800, 16'h0001, 8'd64, C_STD,   1'b0, 1'b0, 2'd0}, // R2 R7 wrong EtherType
    '{UC, SA, 16'h8808, 16'h0001, 8'd64, C_STD,   1'b0, 1'b0, 2'd0}, // R3 unicast check off
    '{UC, SA, 16'h8808, 16'h0001, 8'd64, C_UC,    1'b1, 1'b1, 2'd1}, // R3 unicast check on
    '{MC, SA, 16'h8808, 16'h0002, 8'd64, C_STD,   1'b0, 1'b0, 2'd0}, // R5 unknown opcode
    '{MC, SA, 16'h8808, 16'h0001, 8'd64, C_OFF,   1'b0, 1'b0, 2'd0}, // R10 disabled
    '{MC, 48'h112233445566, 16'h8808, 16'h0001, 8'd64, C_SRC, 1'b0, 1'b0, 2'd0}, // R4 src mismatch
    '{MC, SA, 16'h8808, 16'h0001, 8'd64, C_SRC,   1'b1, 1'b1, 2'd1}, // R4 src match
    '{MC, SA, 16'h8808, 16'h0001, 8'd15, C_STD,   1'b0, 1'b0, 2'd0}, // R2 truncated header
    '{MC, SA, 16'h8808, 16'h0001, 8'd17, C_STD,   1'b1, 1'b1, 2'd1}, // R9 half quanta
    '{48'h020000000099, SA, 16'h8808, 16'h0001, 8'd64, C_NODST, 1'b1, 1'b1, 2'd1}, // R3 no dst checks
    '{MC, SA, 16'h8808, 16'h1234, 8'd64, C_NOOP,  1'b1, 1'b1, 2'd0}, // R5 no opcode checks
    '{MC, SA, 16'h8808, 16'h0101, 8'd25, C_FWD,   1'b0, 1'b1, 2'd2}  // R9 short priority frame
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable, cfg_forward, cfg_mcast_chk, cfg_ucast_chk, cfg_src_chk;
  logic cfg_link_chk, cfg_prio_chk;
  logic [47:0] cfg_mcast_addr = MC, cfg_ucast_addr = UC, cfg_src_addr = SA;
  logic [15:0] cfg_ethtype = 16'h8808, cfg_link_op = 16'h0001, cfg_prio_op = 16'h0101;
  logic in_valid = 1'b0, in_last = 1'b0, in_user = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_last, out_user, ctl_valid;
  logic [7:0] out_data;
  logic [1:0] ctl_kind;
  logic [15:0] ctl_opcode, ctl_word0;
  logic [16*NCL-1:0] ctl_prio_quanta;

  int checks = 0;
  int errors = 0;
  logic [7:0] fb [64];
  logic data_ok, got_user, got_ctl, got_ctl_after;
  logic [1:0] got_kind;
  logic [15:0] got_op, got_w0;
  logic [16*NCL-1:0] got_q;

  always #5 clk = ~clk;

  mcf_rx_classifier #(.NUM_CLASSES(NCL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_forward(cfg_forward),
    .cfg_mcast_addr(cfg_mcast_addr), .cfg_mcast_chk(cfg_mcast_chk),
    .cfg_ucast_addr(cfg_ucast_addr), .cfg_ucast_chk(cfg_ucast_chk),
    .cfg_src_addr(cfg_src_addr), .cfg_src_chk(cfg_src_chk), .cfg_ethtype(cfg_ethtype),
    .cfg_link_op(cfg_link_op), .cfg_link_chk(cfg_link_chk),
    .cfg_prio_op(cfg_prio_op), .cfg_prio_chk(cfg_prio_chk),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_user(in_user),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_user(out_user),
    .ctl_valid(ctl_valid), .ctl_kind(ctl_kind), .ctl_opcode(ctl_opcode),
    .ctl_word0(ctl_word0), .ctl_prio_quanta(ctl_prio_quanta)
  );

  task automatic check(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [5:0] c);
    cfg_enable = c[5]; cfg_forward = c[4]; cfg_mcast_chk = c[3];
    cfg_ucast_chk = c[2]; cfg_src_chk = c[1]; cfg_link_chk = c[0]; cfg_prio_chk = c[0];
  endtask

  task automatic build(input vec_t v);
    for (int j = 0; j < 64; j++) begin
      if (j < 6)       fb[j] = v.dst[8*(5-j) +: 8];
      else if (j < 12) fb[j] = v.src[8*(11-j) +: 8];
      else if (j < 14) fb[j] = v.etype[8*(13-j) +: 8];
      else if (j < 16) fb[j] = v.op[8*(15-j) +: 8];
      else             fb[j] = 8'(8'h10 + j - 16);
    end
  endtask

  function automatic logic [15:0] pword(input int j, input int len);
    return {(j < len) ? fb[j] : 8'h00, (j + 1 < len) ? fb[j+1] : 8'h00};
  endfunction

  task automatic send_frame(input int len, input logic err);
    data_ok = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i > 0 && !(out_valid && out_data == fb[i-1] && !out_last)) data_ok = 1'b0;
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1);
      in_user = (i == len - 1) ? err : 1'b0;
    end
    @(negedge clk);
    if (!(out_valid && out_data == fb[len-1] && out_last)) data_ok = 1'b0;
    got_user = out_user; got_ctl = ctl_valid; got_kind = ctl_kind;
    got_op = ctl_opcode; got_w0 = ctl_word0; got_q = ctl_prio_quanta;
    in_valid = 1'b0; in_last = 1'b0; in_user = 1'b0;
    @(negedge clk);
    got_ctl_after = ctl_valid;
  endtask

  task automatic run_vec(input vec_t v);
    int len;
    len = int'(v.len);
    set_cfg(v.cfg);
    build(v);
    send_frame(len, 1'b0);
    check(data_ok, "R1 pass-through", 64'(data_ok), 64'd1);
    check(got_user == v.exp_mark, "R6/R7 final user bit", 64'(got_user), 64'(v.exp_mark));
    check(got_ctl == v.exp_valid, "R8 ctl_valid", 64'(got_ctl), 64'(v.exp_valid));
    check(!got_ctl_after, "R8 single pulse", 64'(got_ctl_after), 64'd0);
    if (v.exp_valid) begin
      check(got_kind == v.exp_kind, "R5 kind", 64'(got_kind), 64'(v.exp_kind));
      check(got_op == v.op, "R9 opcode", 64'(got_op), 64'(v.op));
      check(got_w0 == pword(16, len), "R9 word0", 64'(got_w0), 64'(pword(16, len)));
      if (v.exp_kind == 2'd2)
        for (int c = 0; c < NCL; c++)
          check(got_q[16*c +: 16] == pword(18 + 2*c, len), "R9 class quanta",
                64'(got_q[16*c +: 16]), 64'(pword(18 + 2*c, len)));
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    set_cfg(C_STD);
    repeat (3) @(negedge clk);
    check(!out_valid && !ctl_valid, "R11 in reset", 64'({out_valid, ctl_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !ctl_valid, "R11 after reset", 64'({out_valid, ctl_valid}), 64'd0);

    for (int n = 0; n < NV; n++) run_vec(VECS[n]);

    // R8 R7: matched frame with upstream error on its last beat
    set_cfg(C_STD);
    build(VECS[0]);
    send_frame(64, 1'b1);
    check(got_user, "R7 error kept", 64'(got_user), 64'd1);
    check(!got_ctl, "R8 errored no strobe", 64'(got_ctl), 64'd0);

    // R10: disabled classifier with errored non-matching frame keeps input bit
    set_cfg(C_OFF);
    build(VECS[3]);
    send_frame(20, 1'b1);
    check(got_user && !got_ctl, "R10 disabled passthrough", 64'({got_user, got_ctl}), 64'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule